// File: doc/BRIEF.md
# Rank-Table Byte Symbol Decoder

This block expands a compact byte code into a stream of output bytes. A 128-entry rank table, filled through a small write port while the decoder is idle, maps symbol indices to byte values, with index 0 holding the most frequent symbol. Each code byte then falls into one of four classes. A low byte carries two small indices and produces two output bytes. The byte 0x7F marks that the next byte is to be copied out unchanged. A byte with the top bit set selects one table entry. The remaining six values are reserved and count as errors.

Code bytes arrive on a valid/ready stream and decoded bytes leave on another. Backpressure on the output stops input from being consumed, so no byte is lost. A pass-through mode copies every input byte straight to the output. This mode is meant for blocks whose byte distribution is too flat for the table to help. A sticky error flag records reserved codes and an escape that ends a stream with no byte after it.

Top module: `psym_decoder`

## Requirements
- R1: A table write (`tbl_we`, `tbl_idx`, `tbl_val`) updates that entry only while `busy` is 0. A write presented while `busy` is 1 leaves the entry unchanged.
- R2: In table mode, a code byte in 0x80..0xFF emits one byte, `table[byte - 0x80]`.
- R3: In table mode, a code byte b in 0x00..0x78 emits two bytes: first `table[b / 11]`, then `table[b % 11]`.
- R4: In table mode, code byte 0x7F emits nothing itself. The next accepted byte, of any value, is emitted unchanged.
- R5: In table mode, a code byte in 0x79..0x7E is dropped and sets `err`. Once set, `err` stays 1 until reset.
- R6: A 0x7F code byte accepted with `in_last` = 1 sets `err` and emits nothing. The byte after it is decoded normally.
- R7: With `raw_mode` = 1, every accepted byte is emitted unchanged, including 0x7F and reserved values.
- R8: While `out_valid` = 1 and `out_ready` = 0, `out_valid` and `out_data` hold. `in_ready` stays 0 until the second byte of a pair has been placed in the output register.
- R9: A byte that emits output immediately shows that output on `out_valid`/`out_data` in the cycle after it is accepted.
- R10: After reset, `out_valid` = 0, `err` = 0, `busy` = 0 and `in_ready` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| raw_mode | input | 1 | 1 = copy bytes through; change only while idle |
| tbl_we | input | 1 | Table write strobe |
| tbl_idx | input | 7 | Table entry to write |
| tbl_val | input | 8 | Byte value to store |
| in_valid | input | 1 | Code byte present |
| in_data | input | 8 | Code byte |
| in_last | input | 1 | Code byte is the last of the stream |
| in_ready | output | 1 | Decoder takes the code byte this cycle |
| out_valid | output | 1 | Decoded byte present |
| out_data | output | 8 | Decoded byte |
| out_ready | input | 1 | Sink takes the decoded byte |
| busy | output | 1 | Decode in progress or output pending |
| err | output | 1 | Sticky error flag |

## Verification
Single-index bytes at both ends of their range show that the index offset is right. Pair bytes 0x00, 0x0C, 0x2D and 0x78 separate quotient from remainder and catch swapped emission order. Escapes followed by 0x7F, a reserved value and a pair code show that the literal path bypasses classification. Running the same streams with random output stalls checks the pair hold and the data hold. A reset between the end-of-stream escape case and the reserved-code case lets each error source be seen on its own.

// File: rtl/psym_pkg.sv
package psym_pkg;
  localparam int PAIR_RADIX = 11;
  localparam logic [7:0] PAIR_TOP = 8'h78;
  localparam logic [7:0] ESC_CODE = 8'h7F;

  typedef enum logic [1:0] {
    K_PAIR   = 2'd0,
    K_SINGLE = 2'd1,
    K_ESC    = 2'd2,
    K_RESV   = 2'd3
  } code_kind_t;

  typedef enum logic [1:0] {
    ST_NORM  = 2'd0,
    ST_ESC   = 2'd1,
    ST_PAIR2 = 2'd2
  } dec_state_t;
endpackage

// File: rtl/psym_rst_sync.sv
module psym_rst_sync (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) sync_q <= 2'b00;
    else              sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/psym_classify.sv
module psym_classify
  import psym_pkg::*;
#(
  parameter int IDX_W = 7
) (
  input  logic [7:0]       code_i,
  output code_kind_t       kind_o,
  output logic [IDX_W-1:0] idx_a_o,
  output logic [IDX_W-1:0] idx_b_o
);
  logic [7:0] quo;
  logic [7:0] rem;

  always_comb begin
    quo = code_i / 8'(PAIR_RADIX);
    rem = code_i % 8'(PAIR_RADIX);
    idx_b_o = IDX_W'(rem);
    if (code_i[7]) begin
      kind_o  = K_SINGLE;
      idx_a_o = IDX_W'(code_i[6:0]);
    end else if (code_i <= PAIR_TOP) begin
      kind_o  = K_PAIR;
      idx_a_o = IDX_W'(quo);
    end else if (code_i == ESC_CODE) begin
      kind_o  = K_ESC;
      idx_a_o = '0;
    end else begin
      kind_o  = K_RESV;
      idx_a_o = '0;
    end
  end

  always_comb begin
    if (kind_o == K_PAIR) begin
      p_pair_range_r3: assert (quo < 8'(PAIR_RADIX) && rem < 8'(PAIR_RADIX));
    end
  end
endmodule

// File: rtl/psym_rank_table.sv
module psym_rank_table #(
  parameter int DEPTH = 128,
  parameter int SYM_W = 8,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [SYM_W-1:0] wr_val,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [SYM_W-1:0] rd_val
);
  logic [SYM_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_val;
  end

  assign rd_val = mem[rd_idx];
endmodule

// File: rtl/psym_decoder.sv
module psym_decoder
  import psym_pkg::*;
#(
  parameter int TBL_DEPTH = 128,
  parameter int SYM_W     = 8,
  parameter int IDX_W     = $clog2(TBL_DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             raw_mode,
  input  logic             tbl_we,
  input  logic [IDX_W-1:0] tbl_idx,
  input  logic [SYM_W-1:0] tbl_val,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  input  logic             in_last,
  output logic             in_ready,
  output logic             out_valid,
  output logic [SYM_W-1:0] out_data,
  input  logic             out_ready,
  output logic             busy,
  output logic             err
);
  logic             rst_i;
  dec_state_t       state_q, state_n;
  logic [IDX_W-1:0] held_q, held_n;
  logic             ov_q, ov_n;
  logic [SYM_W-1:0] od_q, od_n;
  logic             err_q, err_n;
  code_kind_t       kind;
  logic [IDX_W-1:0] idx_a, idx_b, rd_idx;
  logic [SYM_W-1:0] rd_val;
  logic             can_load, accept;

  psym_rst_sync u_rst (.clk(clk), .rst_n_async(rst_n), .rst_n_sync(rst_i));

  psym_classify #(.IDX_W(IDX_W)) u_cls (
    .code_i(in_data), .kind_o(kind), .idx_a_o(idx_a), .idx_b_o(idx_b)
  );

  psym_rank_table #(.DEPTH(TBL_DEPTH), .SYM_W(SYM_W), .IDX_W(IDX_W)) u_tbl (
    .clk(clk), .wr_en(tbl_we && !busy), .wr_idx(tbl_idx), .wr_val(tbl_val),
    .rd_idx(rd_idx), .rd_val(rd_val)
  );

  assign can_load  = !ov_q || out_ready;
  assign in_ready  = (state_q != ST_PAIR2) && can_load;
  assign accept    = in_valid && in_ready;
  assign rd_idx    = (state_q == ST_PAIR2) ? held_q : idx_a;
  assign busy      = (state_q != ST_NORM) || ov_q;
  assign out_valid = ov_q;
  assign out_data  = od_q;
  assign err       = err_q;

  always_comb begin
    state_n = state_q;
    held_n  = held_q;
    od_n    = od_q;
    err_n   = err_q;
    ov_n    = ov_q && !out_ready;
    unique case (state_q)
      ST_PAIR2: begin
        if (can_load) begin
          ov_n    = 1'b1;
          od_n    = rd_val;
          state_n = ST_NORM;
        end
      end
      ST_ESC: begin
        if (accept) begin
          ov_n    = 1'b1;
          od_n    = SYM_W'(in_data);
          state_n = ST_NORM;
        end
      end
      default: begin
        if (accept) begin
          if (raw_mode) begin
            ov_n = 1'b1;
            od_n = SYM_W'(in_data);
          end else begin
            unique case (kind)
              K_PAIR: begin
                ov_n    = 1'b1;
                od_n    = rd_val;
                held_n  = idx_b;
                state_n = ST_PAIR2;
              end
              K_SINGLE: begin
                ov_n = 1'b1;
                od_n = rd_val;
              end
              K_ESC: begin
                if (in_last) err_n   = 1'b1;
                else         state_n = ST_ESC;
              end
              default: err_n = 1'b1;
            endcase
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      state_q <= ST_NORM;
      held_q  <= '0;
      ov_q    <= 1'b0;
      od_q    <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      held_q  <= held_n;
      ov_q    <= ov_n;
      od_q    <= od_n;
      err_q   <= err_n;
    end
  end

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_i)
    ov_q && !out_ready |=> ov_q && $stable(od_q));

  p_err_sticky_r5: assert property (@(posedge clk) disable iff (!rst_i)
    err_q |=> err_q);

  p_resv_err_r5: assert property (@(posedge clk) disable iff (!rst_i)
    accept && !raw_mode && state_q == ST_NORM && kind == K_RESV |=> err_q);

  p_raw_out_r7: assert property (@(posedge clk) disable iff (!rst_i)
    accept && raw_mode && state_q == ST_NORM |=> ov_q && od_q == $past(in_data));

  p_pair_second_r3: assert property (@(posedge clk) disable iff (!rst_i)
    state_q == ST_PAIR2 && can_load |=> ov_q && state_q == ST_NORM);
endmodule

// File: tb/psym_decoder_test.sv
module psym_decoder_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       raw_mode = 1'b0;
  logic       tbl_we = 1'b0;
  logic [6:0] tbl_idx = '0;
  logic [7:0] tbl_val = '0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_last = 1'b0;
  logic       in_ready;
  logic       out_valid;
  logic [7:0] out_data;
  logic       out_ready = 1'b1;
  logic       busy;
  logic       err;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit stall_mode = 1'b0;
  bit hold_low = 1'b0;
  bit model_on = 1'b0;

  logic [7:0] m_tbl [128];
  logic [7:0] exp_q [$];
  string      tag_q [$];
  bit         m_err = 1'b0;
  bit         m_esc = 1'b0;
  bit         exp_valid_next = 1'b0;
  bit         prev_stall = 1'b0;
  logic [7:0] prev_data = '0;

  always #4 clk = ~clk;

  psym_decoder uut (
    .clk(clk), .rst_n(rst_n), .raw_mode(raw_mode),
    .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_val(tbl_val),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
    .busy(busy), .err(err)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push_exp(input logic [7:0] v, input string req);
    exp_q.push_back(v);
    tag_q.push_back(req);
  endtask

  always @(negedge clk) begin
    if (hold_low)        out_ready = 1'b0;
    else if (stall_mode) out_ready = ($urandom % 3) != 0;
    else                 out_ready = 1'b1;
  end

  // cycle-based reference model, evaluated on pre-edge values
  always @(posedge clk) begin
    cycles++;
    if (model_on) begin
      check(err === m_err, "R5/R6 err", int'(err), int'(m_err));
      if (exp_valid_next) check(out_valid === 1'b1, "R9 latency", int'(out_valid), 1);
      if (prev_stall) check(out_valid === 1'b1 && out_data === prev_data, "R8 hold",
                            int'(out_data), int'(prev_data));
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R3 extra output", int'(out_data), -1);
        end else begin
          logic [7:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(out_data === e, t, int'(out_data), int'(e));
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_data  = out_data;
      exp_valid_next = 1'b0;
      if (in_valid && in_ready) begin
        logic [7:0] b;
        b = in_data;
        if (m_esc) begin
          push_exp(b, "R4 literal"); m_esc = 1'b0; exp_valid_next = 1'b1;
        end else if (raw_mode) begin
          push_exp(b, "R7 raw"); exp_valid_next = 1'b1;
        end else if (b[7]) begin
          push_exp(m_tbl[b[6:0]], "R2 single"); exp_valid_next = 1'b1;
        end else if (b <= 8'h78) begin
          push_exp(m_tbl[int'(b) / 11], "R3 pair first");
          push_exp(m_tbl[int'(b) % 11], "R3 pair second");
          exp_valid_next = 1'b1;
        end else if (b == 8'h7F) begin
          if (in_last) m_err = 1'b1;
          else         m_esc = 1'b1;
        end else begin
          m_err = 1'b1;
        end
      end
    end
  end

  task automatic send(input logic [7:0] b, input bit last);
    @(negedge clk);
    in_valid = 1'b1; in_data = b; in_last = last;
    do @(posedge clk); while (!in_ready);
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic drain();
    int n = 0;
    while ((exp_q.size() != 0 || busy) && n < 200) begin
      @(negedge clk);
      n++;
    end
    check(exp_q.size() == 0, "R3 drain", exp_q.size(), 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    model_on = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    exp_q.delete(); tag_q.delete();
    m_err = 1'b0; m_esc = 1'b0; exp_valid_next = 1'b0; prev_stall = 1'b0;
    repeat (4) @(negedge clk);
    check(out_valid === 1'b0, "R10 out_valid", int'(out_valid), 0);
    check(err === 1'b0, "R10 err", int'(err), 0);
    check(busy === 1'b0, "R10 busy", int'(busy), 0);
    check(in_ready === 1'b1, "R10 in_ready", int'(in_ready), 1);
    model_on = 1'b1;
  endtask

  task automatic write_tbl(input int i, input logic [7:0] v);
    @(negedge clk);
    tbl_we = 1'b1; tbl_idx = 7'(i); tbl_val = v;
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic run_codes();
    send(8'h80, 0); send(8'hFF, 0); send(8'h8A, 0);
    send(8'h00, 0); send(8'h78, 0); send(8'h0C, 0); send(8'h2D, 0);
    send(8'h7F, 0); send(8'h7F, 0);
    send(8'h7F, 0); send(8'h7A, 0);
    send(8'h7F, 0); send(8'h2D, 0);
    send(8'h85, 0); send(8'h01, 0);
    drain();
  endtask

  task automatic finish_up();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cycles > 100000) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=done", cycles);
      finish_up();
    end
  end

  initial begin
    do_reset();
    for (int i = 0; i < 128; i++) begin
      m_tbl[i] = 8'(i * 7 + 3) ^ 8'h5A;
      write_tbl(i, m_tbl[i]);
    end
    // R2 R3 R4 with output always ready, then with random stalls (R8)
    run_codes();
    stall_mode = 1'b1;
    run_codes();
    stall_mode = 1'b0;
    // R1: write accepted while idle
    m_tbl[3] = 8'hC3;
    write_tbl(3, 8'hC3);
    send(8'h83, 0);
    drain();
    // R1: write while busy is ignored
    hold_low = 1'b1;
    send(8'h85, 0);
    @(negedge clk);
    check(busy === 1'b1, "R1 busy during write", int'(busy), 1);
    tbl_we = 1'b1; tbl_idx = 7'd5; tbl_val = ~m_tbl[5];
    @(negedge clk);
    tbl_we = 1'b0;
    hold_low = 1'b0;
    drain();
    send(8'h85, 0);
    drain();
    // R6: escape at end of stream, then normal decode continues
    send(8'h7F, 1);
    send(8'h90, 0);
    drain();
    check(err === 1'b1, "R6 err", int'(err), 1);
    // R5: reserved codes after a fresh reset
    do_reset();
    send(8'h79, 0);
    send(8'h81, 0);
    send(8'h7E, 0);
    drain();
    check(err === 1'b1, "R5 err", int'(err), 1);
    // R7: pass-through mode
    do_reset();
    raw_mode = 1'b1;
    send(8'h7F, 0); send(8'h79, 0); send(8'h05, 0); send(8'h90, 0);
    stall_mode = 1'b1;
    send(8'h7F, 1); send(8'h00, 0);
    drain();
    check(err === 1'b0, "R7 no err", int'(err), 0);
    finish_up();
  end
endmodule